// File: doc/BRIEF.md
# Trigger-Level UART Interrupt Controller

This block turns the fill levels of a UART's transmit and receive FIFOs, plus a handful of one-cycle event strobes, into four sticky interrupt source bits. A mask register filters those bits into a pending register. Any nonzero pending value drives a single interrupt line. The block also drives a busy line for a receive DMA engine. It holds no FIFO storage and does no serialisation. The surrounding UART supplies the counts, the control fields and the strobes.

The FIFO thresholds depend on the channel number, because each channel has its own FIFO depth. A 3-bit level field is multiplied by a per-channel scale. The transmit threshold uses the field directly, while the receive threshold uses the field plus one. Software reaches the pending, source and mask registers through a small word-wide port. Writing ones to the pending or source address clears those bits. A source condition that still holds sets its bit again on the same edge.

Top module: `uirq_ctrl`

## Requirements
- R1: After synchronous reset, the source, pending and mask registers read zero, and `irq` and `dma_busy` are low. Source bit positions are: receive = bit 0, error = bit 1, transmit = bit 2, modem = bit 3.
- R2: The threshold scale is 32 for channel 0, 8 for channels 1 and 4, and 2 for channels 2 and 3. Any other channel gives both thresholds a value of 0, so in FIFO mode the receive source is then always set.
- R3: The transmit threshold is `tx_lvl_sel` times the scale. With `fifo_en` high, the transmit source bit is set on the next edge whenever `tx_count` is less than or equal to that threshold.
- R4: The receive threshold is (`rx_lvl_sel` + 1) times the scale, and can reach 256. With `fifo_en` high, the receive source bit is set on the next edge when `rx_count` is at or above the threshold.
- R5: With `fifo_en` high and `rx_tmo_en` low, a nonzero `rx_count` sets the receive source bit. A zero count never does.
- R6: With `fifo_en` low, `data_ready` sets the receive source bit, and the transmit level rule has no effect.
- R7: `err_strobe` sets bit 1, `tmo_strobe` sets bit 0, `tx_done_strobe` sets bit 2 and `modem_strobe` sets bit 3, each on the next edge.
- R8: The pending register equals source AND NOT mask, updated on the same edge as the source. `irq` is high exactly when pending is nonzero.
- R9: A write to address 0 (pending) clears the written one-bits in both source and pending. A set condition active in the same cycle wins.
- R10: A write to address 1 (source) clears the written one-bits of the source. Pending follows on the same edge.
- R11: A write to address 2 (mask) loads the mask. The masking takes effect on `irq` and pending after that clock edge.
- R12: `dma_busy` goes high one edge after `rx_mode` equals 2 while `rx_count` is zero. It is low otherwise.
- R13: `reg_rdata` reads pending at address 0, source at 1 and mask at 2, combinationally. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_count | input | CNT_W | Transmit FIFO fill count |
| rx_count | input | CNT_W | Receive FIFO fill count |
| fifo_en | input | 1 | FIFO mode enable |
| tx_lvl_sel | input | 3 | Transmit trigger level field |
| rx_lvl_sel | input | 3 | Receive trigger level field |
| chan_id | input | CHAN_W | Channel number selecting the scale |
| rx_tmo_en | input | 1 | Receive timeout enabled |
| rx_mode | input | 2 | Receive service mode; 2 selects DMA |
| data_ready | input | 1 | Receive holding data valid (non-FIFO mode) |
| err_strobe | input | 1 | Error event pulse |
| tmo_strobe | input | 1 | Receive timeout event pulse |
| tx_done_strobe | input | 1 | Transmit-done event pulse |
| modem_strobe | input | 1 | Modem event pulse |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Register read data |
| irq | output | 1 | Interrupt request |
| dma_busy | output | 1 | Receive DMA busy |

## Verification
The bench uses the default widths: 8-bit counts and a 3-bit channel number. With those widths it can drive every channel value, including the unsupported ones 5 to 7 whose thresholds are zero. The 8-bit counts reach both sides of the largest thresholds: a transmit threshold of 224 and a receive threshold of 256. A count of 255 is compared against that 256, which exercises the widened comparison. Walking every channel through the level fields covers all four scale factors. The pairs of counts just either side of each threshold check the less-or-equal and at-or-above rules.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int NSRC    = 4;
    localparam int SRC_RX  = 0;
    localparam int SRC_ERR = 1;
    localparam int SRC_TX  = 2;
    localparam int SRC_MDM = 3;

    localparam int LVL_W     = 3;
    localparam int SCALE_MAX = 32;
    localparam int SCALE_W   = $clog2(SCALE_MAX + 1);
    localparam int THR_W     = $clog2(((1 << LVL_W) * SCALE_MAX) + 1);

    localparam logic [1:0] RXMODE_DMA = 2'd2;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef enum logic [1:0] {
        ADDR_PEND = 2'd0,
        ADDR_SRC  = 2'd1,
        ADDR_MASK = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic      we;
        reg_addr_e addr;
        src_vec_t  data;
    } reg_req_t;

    typedef struct packed {
        logic [THR_W-1:0] tx;
        logic [THR_W-1:0] rx;
    } thr_pair_t;

    // Per-channel multiplier applied to the level fields.
    function automatic logic [SCALE_W-1:0] trig_scale(input int unsigned ch);
        case (ch)
            0:       return SCALE_W'(32);
            1, 4:    return SCALE_W'(8);
            2, 3:    return SCALE_W'(2);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/uirq_thresh.sv
module uirq_thresh
    import uirq_pkg::*;
#(
    parameter int CHAN_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CHAN_W-1:0] chan_id,
    input  logic [LVL_W-1:0]  tx_lvl_sel,
    input  logic [LVL_W-1:0]  rx_lvl_sel,
    output thr_pair_t         thr
);

    logic [SCALE_W-1:0] scale;
    logic [THR_W-1:0]   rx_steps;

    always_comb begin
        scale    = trig_scale(32'(chan_id));
        rx_steps = THR_W'(rx_lvl_sel) + THR_W'(1);
        thr.tx   = THR_W'(THR_W'(tx_lvl_sel) * THR_W'(scale));
        thr.rx   = THR_W'(rx_steps * THR_W'(scale));
    end

    // R2: unsupported channel numbers yield zero thresholds
    a_r2_bad_chan_zero: assert property (@(posedge clk) disable iff (rst)
        (chan_id > CHAN_W'(4)) |-> (thr.tx == '0 && thr.rx == '0));

endmodule

// File: rtl/uirq_level.sv
module uirq_level
    import uirq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  thr_pair_t        thr,
    input  logic             fifo_en,
    input  logic             rx_tmo_en,
    input  logic             data_ready,
    input  logic             err_strobe,
    input  logic             tmo_strobe,
    input  logic             tx_done_strobe,
    input  logic             modem_strobe,
    output src_vec_t         set_vec
);

    localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

    logic [CMP_W-1:0] tx_c, rx_c, tx_t, rx_t;
    logic             tx_low, rx_hit, rx_any;

    always_comb begin
        tx_c   = CMP_W'(tx_count);
        rx_c   = CMP_W'(rx_count);
        tx_t   = CMP_W'(thr.tx);
        rx_t   = CMP_W'(thr.rx);
        tx_low = (tx_c <= tx_t);
        rx_hit = (rx_c >= rx_t);
        rx_any = (rx_c != '0) && !rx_tmo_en;

        set_vec          = '0;
        set_vec[SRC_RX]  = tmo_strobe | (fifo_en ? (rx_hit | rx_any) : data_ready);
        set_vec[SRC_ERR] = err_strobe;
        set_vec[SRC_TX]  = tx_done_strobe | (fifo_en & tx_low);
        set_vec[SRC_MDM] = modem_strobe;
    end

endmodule

// File: rtl/uirq_regs.sv
module uirq_regs
    import uirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t set_vec,
    input  reg_req_t req,
    output src_vec_t src_q,
    output src_vec_t pend_q,
    output src_vec_t mask_q
);

    src_vec_t clr_vec, src_d, mask_d, pend_d;

    always_comb begin
        clr_vec = '0;
        if (req.we && (req.addr == ADDR_PEND || req.addr == ADDR_SRC))
            clr_vec = req.data;
        mask_d = (req.we && req.addr == ADDR_MASK) ? req.data : mask_q;
    end

    for (genvar b = 0; b < NSRC; b++) begin : g_bit
        always_comb begin
            src_d[b]  = (src_q[b] & ~clr_vec[b]) | set_vec[b];
            pend_d[b] = src_d[b] & ~mask_d[b];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            pend_q <= '0;
            mask_q <= '0;
        end else begin
            src_q  <= src_d;
            pend_q <= pend_d;
            mask_q <= mask_d;
        end
    end

    // R8: nothing masked is ever pending
    a_r8_pend_disjoint_mask: assert property (@(posedge clk) disable iff (rst)
        (pend_q & mask_q) == '0);

    // R9: a pending write removes its bits unless re-set in that cycle
    a_r9_pend_write_clears: assert property (@(posedge clk) disable iff (rst)
        (req.we && req.addr == ADDR_PEND)
        |=> ((src_q & $past(req.data & ~set_vec)) == '0));

    // R10: a source write removes its bits unless re-set in that cycle
    a_r10_src_write_clears: assert property (@(posedge clk) disable iff (rst)
        (req.we && req.addr == ADDR_SRC)
        |=> ((src_q & $past(req.data & ~set_vec)) == '0));

endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
    import uirq_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int CHAN_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic              fifo_en,
    input  logic [2:0]        tx_lvl_sel,
    input  logic [2:0]        rx_lvl_sel,
    input  logic [CHAN_W-1:0] chan_id,
    input  logic              rx_tmo_en,
    input  logic [1:0]        rx_mode,
    input  logic              data_ready,
    input  logic              err_strobe,
    input  logic              tmo_strobe,
    input  logic              tx_done_strobe,
    input  logic              modem_strobe,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [3:0]        reg_wdata,
    output logic [3:0]        reg_rdata,
    output logic              irq,
    output logic              dma_busy
);

    thr_pair_t thr;
    src_vec_t  set_vec, src_q, pend_q, mask_q;
    reg_req_t  req;
    logic      dma_q;

    always_comb begin
        req.we   = reg_we;
        req.addr = reg_addr_e'(reg_addr);
        req.data = reg_wdata;
    end

    uirq_thresh #(.CHAN_W(CHAN_W)) u_thresh (
        .clk        (clk),
        .rst        (rst),
        .chan_id    (chan_id),
        .tx_lvl_sel (tx_lvl_sel),
        .rx_lvl_sel (rx_lvl_sel),
        .thr        (thr)
    );

    uirq_level #(.CNT_W(CNT_W)) u_level (
        .tx_count       (tx_count),
        .rx_count       (rx_count),
        .thr            (thr),
        .fifo_en        (fifo_en),
        .rx_tmo_en      (rx_tmo_en),
        .data_ready     (data_ready),
        .err_strobe     (err_strobe),
        .tmo_strobe     (tmo_strobe),
        .tx_done_strobe (tx_done_strobe),
        .modem_strobe   (modem_strobe),
        .set_vec        (set_vec)
    );

    uirq_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .req     (req),
        .src_q   (src_q),
        .pend_q  (pend_q),
        .mask_q  (mask_q)
    );

    always_ff @(posedge clk) begin
        if (rst) dma_q <= 1'b0;
        else     dma_q <= (rx_mode == RXMODE_DMA) && (rx_count == '0);
    end

    always_comb begin
        case (req.addr)
            ADDR_PEND: reg_rdata = pend_q;
            ADDR_SRC:  reg_rdata = src_q;
            ADDR_MASK: reg_rdata = mask_q;
            default:   reg_rdata = '0;
        endcase
        irq      = |pend_q;
        dma_busy = dma_q;
    end

    // R8: the line is only raised by an unmasked source bit
    a_r8_irq_has_source: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((src_q & ~mask_q) != '0));

    // R7: the error strobe lands in bit 1
    a_r7_err_sets: assert property (@(posedge clk) disable iff (rst)
        err_strobe |=> src_q[SRC_ERR]);

    // R6: without FIFO mode the receive bit follows data-ready
    a_r6_dready_sets: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && data_ready) |=> src_q[SRC_RX]);

    // R3: transmit level at or below threshold sets bit 2
    a_r3_tx_level: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && ({1'b0, tx_count} <= {1'b0, thr.tx})) |=> src_q[SRC_TX]);

    // R12: DMA mode with an empty receive FIFO reports busy
    a_r12_dma_busy: assert property (@(posedge clk) disable iff (rst)
        (rx_mode == RXMODE_DMA && rx_count == '0) |=> dma_busy);

endmodule

// File: tb/uirq_ctrl_bench.sv
`timescale 1ns/1ps
module uirq_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] tx_count, rx_count;
    logic       fifo_en;
    logic [2:0] tx_lvl_sel, rx_lvl_sel, chan_id;
    logic       rx_tmo_en;
    logic [1:0] rx_mode;
    logic       data_ready, err_strobe, tmo_strobe, tx_done_strobe, modem_strobe;
    logic       reg_we;
    logic [1:0] reg_addr;
    logic [3:0] reg_wdata, reg_rdata;
    logic       irq, dma_busy;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    uirq_ctrl u_uirq_ctrl (
        .clk(clk), .rst(rst), .tx_count(tx_count), .rx_count(rx_count),
        .fifo_en(fifo_en), .tx_lvl_sel(tx_lvl_sel), .rx_lvl_sel(rx_lvl_sel),
        .chan_id(chan_id), .rx_tmo_en(rx_tmo_en), .rx_mode(rx_mode),
        .data_ready(data_ready), .err_strobe(err_strobe), .tmo_strobe(tmo_strobe),
        .tx_done_strobe(tx_done_strobe), .modem_strobe(modem_strobe),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .dma_busy(dma_busy)
    );

    // {chan, tx_sel, rx_sel, tx_count, rx_count, tmo_en, exp_tx, exp_rx}
    localparam logic [27:0] TBL [12] = '{
        {3'd0, 3'd1, 3'd0, 8'd32,  8'd31,  1'b1, 1'b1, 1'b0},
        {3'd0, 3'd1, 3'd0, 8'd33,  8'd32,  1'b1, 1'b0, 1'b1},
        {3'd1, 3'd2, 3'd1, 8'd16,  8'd15,  1'b1, 1'b1, 1'b0},
        {3'd4, 3'd0, 3'd1, 8'd1,   8'd16,  1'b1, 1'b0, 1'b1},
        {3'd2, 3'd3, 3'd2, 8'd7,   8'd5,   1'b1, 1'b0, 1'b0},
        {3'd3, 3'd7, 3'd7, 8'd14,  8'd16,  1'b1, 1'b1, 1'b1},
        {3'd3, 3'd0, 3'd7, 8'd0,   8'd1,   1'b0, 1'b1, 1'b1},
        {3'd5, 3'd7, 3'd7, 8'd0,   8'd0,   1'b1, 1'b1, 1'b1},
        {3'd6, 3'd5, 3'd3, 8'd1,   8'd0,   1'b1, 1'b0, 1'b1},
        {3'd0, 3'd7, 3'd7, 8'd200, 8'd255, 1'b1, 1'b1, 1'b0},
        {3'd2, 3'd0, 3'd0, 8'd0,   8'd1,   1'b1, 1'b1, 1'b0},
        {3'd1, 3'd1, 3'd0, 8'd9,   8'd0,   1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [3:0] exp, input string tag);
        reg_addr = a;
        #0.5;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk);
        s = 1'b1;
        @(negedge clk);
        s = 1'b0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tx_count = 8'd0; rx_count = 8'd0; fifo_en = 1'b0;
        tx_lvl_sel = 3'd0; rx_lvl_sel = 3'd0; chan_id = 3'd0; rx_tmo_en = 1'b1;
        rx_mode = 2'd0; data_ready = 1'b0; err_strobe = 1'b0; tmo_strobe = 1'b0;
        tx_done_strobe = 1'b0; modem_strobe = 1'b0;
        reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = 4'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        rd_chk(2'd0, 4'h0, "R1 pending after reset");
        rd_chk(2'd1, 4'h0, "R1 source after reset");
        rd_chk(2'd2, 4'h0, "R1 mask after reset");
        chk("R1 irq/dma after reset", {2'b0, irq, dma_busy}, 4'h0);

        // R2 R3 R4 R5: threshold table, tx = bit 2, rx = bit 0
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            {chan_id, tx_lvl_sel, rx_lvl_sel, tx_count, rx_count, rx_tmo_en} = TBL[i][27:2];
            fifo_en = 1'b1;
            @(negedge clk);
            rd_chk(2'd1, {1'b0, TBL[i][1], 1'b0, TBL[i][0]},
                   $sformatf("R2/R3/R4/R5 table row %0d", i));
            fifo_en = 1'b0;
            wr(2'd1, 4'hF);
        end
        chan_id = 3'd0; tx_count = 8'd0; rx_count = 8'd0; rx_tmo_en = 1'b1;
        tx_lvl_sel = 3'd0; rx_lvl_sel = 3'd0;
        rd_chk(2'd1, 4'h0, "R10 source cleared after table");

        // R7 R8: error strobe, unmasked
        pulse(err_strobe);
        rd_chk(2'd1, 4'h2, "R7 error strobe to bit 1");
        rd_chk(2'd0, 4'h2, "R8 pending follows source");
        chk("R8 irq high", {3'b0, irq}, 4'h1);

        // R11: mask hides it after the edge
        wr(2'd2, 4'h2);
        rd_chk(2'd0, 4'h0, "R11 masked pending");
        chk("R11 irq low when masked", {3'b0, irq}, 4'h0);
        rd_chk(2'd2, 4'h2, "R11 mask readback");
        rd_chk(2'd1, 4'h2, "R11 source untouched by mask");
        wr(2'd2, 4'h0);
        rd_chk(2'd0, 4'h2, "R11 unmask restores pending");

        // R9: pending write clears both
        wr(2'd0, 4'h2);
        rd_chk(2'd1, 4'h0, "R9 pending write clears source");
        rd_chk(2'd0, 4'h0, "R9 pending write clears pending");
        chk("R9 irq low after clear", {3'b0, irq}, 4'h0);

        // R7: remaining strobes
        pulse(tmo_strobe);
        rd_chk(2'd1, 4'h1, "R7 timeout strobe to bit 0");
        pulse(tx_done_strobe);
        rd_chk(2'd1, 4'h5, "R7 tx-done strobe to bit 2");
        pulse(modem_strobe);
        rd_chk(2'd1, 4'hD, "R7 modem strobe to bit 3");
        // R13: unused address reads zero
        rd_chk(2'd3, 4'h0, "R13 address 3 reads zero");

        // R10: source write clears source, pending follows
        wr(2'd1, 4'hF);
        rd_chk(2'd1, 4'h0, "R10 source write clears source");
        rd_chk(2'd0, 4'h0, "R10 pending follows source clear");

        // R9: active condition wins over a clearing write
        @(negedge clk);
        fifo_en = 1'b1; tx_count = 8'd0; rx_count = 8'd0; rx_tmo_en = 1'b1;
        @(negedge clk);
        rd_chk(2'd1, 4'h4, "R9 tx level condition set");
        wr(2'd0, 4'h4);
        rd_chk(2'd1, 4'h4, "R9 set wins over pending clear");
        @(negedge clk);
        fifo_en = 1'b0;
        wr(2'd1, 4'hF);
        rd_chk(2'd1, 4'h0, "R6 tx rule inactive without FIFO mode");

        // R6: data-ready path without FIFO mode
        @(negedge clk);
        data_ready = 1'b1;
        @(negedge clk);
        rd_chk(2'd1, 4'h1, "R6 data-ready sets receive");
        data_ready = 1'b0;
        wr(2'd1, 4'hF);
        rd_chk(2'd1, 4'h0, "R6 cleared once data-ready drops");

        // R12: DMA busy
        @(negedge clk);
        rx_mode = 2'd2; rx_count = 8'd0;
        @(negedge clk);
        chk("R12 dma busy on empty", {3'b0, dma_busy}, 4'h1);
        rx_count = 8'd3;
        @(negedge clk);
        chk("R12 dma idle with data", {3'b0, dma_busy}, 4'h0);
        rx_mode = 2'd1; rx_count = 8'd0;
        @(negedge clk);
        chk("R12 dma idle in other mode", {3'b0, dma_busy}, 4'h0);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule